// File: doc/BRIEF.md
# Single-Bus Register Datapath

This block is the register side of a 32-bit processor whose units all talk over one shared internal bus. It holds a program counter, a memory address register, a memory data register, an instruction register, an operand holding register (Y), a result register (Z) and a bank of 32 general registers. An external sequencer drives the block one step per clock. In each step it raises at most one "drive" strobe, which places a source on the bus, and any number of "load" strobes, which capture the bus into their registers at the next clock edge.

The arithmetic unit sits outside the block. The datapath hands it two operands. Operand A is either Y or the constant 4, picked by a select line; operand B is always the bus. The datapath takes the result back into Z. Z must then drive the bus before the result reaches its destination. Incrementing the program counter uses the same path: drive the PC, select the constant, capture into Z, then move Z into the PC.

Memory is reached through the address register, which drives the address lines at all times. Read and write requests are single-cycle strobes, and memory answers each with a completion pulse. The data register loads either from the memory read data, on a completion pulse, or from the bus when a store is being prepared. The low 16 bits of the instruction register form a signed offset or immediate that can drive the bus.

Top module: `sbus_datapath`

## Requirements
- R1: While reset is asserted and through the first clock edges after its release, every register in the block holds zero. This covers the PC, address, data, instruction, Y and Z registers and all 32 general registers. After reset, mem_addr and mem_wdata read 0, and alu_a reads 0 with opa_sel_four low.
- R2: When no drive strobe is high, bus_q is 0. When exactly one drive strobe is high, bus_q equals that source. At most one drive strobe may be high in any cycle.
- R3: With gpr_load high, general register gpr_wr_sel takes bus_q at the clock edge, and no other general register changes. With gpr_drive high, bus_q equals general register gpr_rd_sel, so one step can copy one register into another.
- R4: With pc_load high, the PC takes bus_q at the clock edge. With pc_drive high, bus_q equals the PC.
- R5: With mar_load high, the address register takes bus_q at the clock edge. mem_addr shows the address register in every cycle and does not change while mar_load is low.
- R6: When mdr_load_ext and mem_mfc are both high, the data register takes mem_rdata at the clock edge. When mdr_load_ext is high and mem_mfc is low, the data register holds. mem_wdata always shows the data register, and mdr_drive places it on the bus.
- R7: With mdr_load_int high, the data register takes bus_q at the clock edge. If a memory capture (R6) happens in the same cycle, the memory data wins.
- R8: With ir_load high, the instruction register takes bus_q. With ir_drive_ofs high, bus_q equals bits 15:0 of the instruction register, sign-extended from bit 15 to 32 bits.
- R9: alu_b always equals bus_q. alu_a equals 4 when opa_sel_four is 1, and otherwise equals Y. Y takes bus_q at the clock edge when y_load is high.
- R10: With z_load high, Z takes alu_y at the clock edge. With z_drive high, bus_q equals Z.
- R11: mem_rd follows rd_req and mem_wr follows wr_req in the same cycle, without added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_drive | input | 1 | Place PC on the bus |
| pc_load | input | 1 | Capture bus into PC |
| mar_load | input | 1 | Capture bus into address register |
| mdr_drive | input | 1 | Place data register on the bus |
| mdr_load_int | input | 1 | Capture bus into data register |
| mdr_load_ext | input | 1 | Capture mem_rdata into data register on mem_mfc |
| ir_drive_ofs | input | 1 | Place sign-extended IR offset on the bus |
| ir_load | input | 1 | Capture bus into instruction register |
| y_load | input | 1 | Capture bus into Y |
| z_drive | input | 1 | Place Z on the bus |
| z_load | input | 1 | Capture alu_y into Z |
| gpr_drive | input | 1 | Place selected general register on the bus |
| gpr_rd_sel | input | 5 | General register that drives the bus |
| gpr_load | input | 1 | Capture bus into a general register |
| gpr_wr_sel | input | 5 | General register that is written |
| opa_sel_four | input | 1 | 1: operand A is 4, 0: operand A is Y |
| alu_a | output | 32 | Operand A to the external ALU |
| alu_b | output | 32 | Operand B to the external ALU (the bus) |
| alu_y | input | 32 | Result from the external ALU |
| rd_req | input | 1 | Read request strobe |
| wr_req | input | 1 | Write request strobe |
| mem_addr | output | 32 | Memory address (address register) |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_mfc | input | 1 | Memory function complete pulse |
| mem_rdata | input | 32 | Memory read data |
| mem_wdata | output | 32 | Memory write data (data register) |
| bus_q | output | 32 | Current value of the internal bus |

## Verification
The general register bank is swept in full. Each of the 32 registers gets a distinct value derived from its index, and then each is read back. This sweep tells apart a crossed select, a missed write enable and a write that also lands in a neighbouring register. Offset extension is tried with words whose low halves sit on either side of the sign boundary (0x0000, 0x7FFF, 0x8000, 0xFFFF and a mid value), and whose upper halves carry junk. These words show whether extension uses bit 15 and whether the upper IR bits leak onto the bus. The data register is tried with a capture held back while completion is low, with a bus load, and with both loads in one cycle, which shows the hold behaviour and which load takes priority. A PC increment through the constant-4 operand and Z shows the operand select and the Z round trip.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  // One flag per bus source; the sequencer raises at most one per step.
  typedef struct packed {
    logic pc;
    logic mdr;
    logic ofs;
    logic z;
    logic gpr;
  } drv_t;

endpackage

// File: rtl/sbus_reg.sv
module sbus_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int unsigned W     = 32,
  parameter int unsigned N     = 32,
  localparam int unsigned SEL_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [W-1:0]     rd_data
);

  logic [W-1:0] cell_q [N];

  for (genvar g = 0; g < N; g++) begin : g_cell
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(g));
    sbus_reg #(.W(W)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (hit),
      .d    (wr_data),
      .q    (cell_q[g])
    );
  end

  assign rd_data = cell_q[rd_sel];

endmodule

// File: rtl/sbus_busmux.sv
module sbus_busmux
  import sbus_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  drv_t         drv,
  input  logic [W-1:0] pc_q,
  input  logic [W-1:0] mdr_q,
  input  logic [W-1:0] ofs_q,
  input  logic [W-1:0] z_q,
  input  logic [W-1:0] gpr_q,
  output logic [W-1:0] bus
);

  // AND-OR merge: one level of gating, idle bus reads zero.
  always_comb begin
    bus = ({W{drv.pc}}  & pc_q)
        | ({W{drv.mdr}} & mdr_q)
        | ({W{drv.ofs}} & ofs_q)
        | ({W{drv.z}}   & z_q)
        | ({W{drv.gpr}} & gpr_q);
  end

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned REG_CNT = 32,
  parameter int unsigned OFS_W   = 16,
  parameter int unsigned STEP    = 4,
  localparam int unsigned SEL_W  = $clog2(REG_CNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pc_drive,
  input  logic             pc_load,
  input  logic             mar_load,
  input  logic             mdr_drive,
  input  logic             mdr_load_int,
  input  logic             mdr_load_ext,
  input  logic             ir_drive_ofs,
  input  logic             ir_load,
  input  logic             y_load,
  input  logic             z_drive,
  input  logic             z_load,
  input  logic             gpr_drive,
  input  logic [SEL_W-1:0] gpr_rd_sel,
  input  logic             gpr_load,
  input  logic [SEL_W-1:0] gpr_wr_sel,
  input  logic             opa_sel_four,
  output logic [W-1:0]     alu_a,
  output logic [W-1:0]     alu_b,
  input  logic [W-1:0]     alu_y,
  input  logic             rd_req,
  input  logic             wr_req,
  output logic [W-1:0]     mem_addr,
  output logic             mem_rd,
  output logic             mem_wr,
  input  logic             mem_mfc,
  input  logic [W-1:0]     mem_rdata,
  output logic [W-1:0]     mem_wdata,
  output logic [W-1:0]     bus_q
);

  // Reset: asserted at once, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [W-1:0] pc_q, mar_q, mdr_q, ir_q, y_q, z_q, gpr_q, ofs_ext;
  logic [W-1:0] mdr_d;
  logic         mdr_take_mem, mdr_en;
  drv_t         drv;

  assign drv = '{pc: pc_drive, mdr: mdr_drive, ofs: ir_drive_ofs,
                 z: z_drive, gpr: gpr_drive};

  assign ofs_ext = {{(W-OFS_W){ir_q[OFS_W-1]}}, ir_q[OFS_W-1:0]};

  sbus_busmux #(.W(W)) u_bus (
    .drv  (drv),
    .pc_q (pc_q),
    .mdr_q(mdr_q),
    .ofs_q(ofs_ext),
    .z_q  (z_q),
    .gpr_q(gpr_q),
    .bus  (bus_q)
  );

  sbus_reg #(.W(W)) u_pc  (.clk(clk), .rst_n(rst_int_n), .en(pc_load),  .d(bus_q), .q(pc_q));
  sbus_reg #(.W(W)) u_mar (.clk(clk), .rst_n(rst_int_n), .en(mar_load), .d(bus_q), .q(mar_q));
  sbus_reg #(.W(W)) u_ir  (.clk(clk), .rst_n(rst_int_n), .en(ir_load),  .d(bus_q), .q(ir_q));
  sbus_reg #(.W(W)) u_y   (.clk(clk), .rst_n(rst_int_n), .en(y_load),   .d(bus_q), .q(y_q));
  sbus_reg #(.W(W)) u_z   (.clk(clk), .rst_n(rst_int_n), .en(z_load),   .d(alu_y), .q(z_q));

  // Data register: a completed memory read takes priority over a bus load.
  always_comb begin
    mdr_take_mem = mdr_load_ext && mem_mfc;
    mdr_en       = mdr_take_mem || mdr_load_int;
    mdr_d        = mdr_take_mem ? mem_rdata : bus_q;
  end

  sbus_reg #(.W(W)) u_mdr (.clk(clk), .rst_n(rst_int_n), .en(mdr_en), .d(mdr_d), .q(mdr_q));

  sbus_regfile #(.W(W), .N(REG_CNT)) u_gpr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (gpr_load),
    .wr_sel (gpr_wr_sel),
    .wr_data(bus_q),
    .rd_sel (gpr_rd_sel),
    .rd_data(gpr_q)
  );

  assign alu_a     = opa_sel_four ? W'(STEP) : y_q;
  assign alu_b     = bus_q;
  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_rd    = rd_req;
  assign mem_wr    = wr_req;

endmodule

// File: rtl/sbus_checker.sv
module sbus_checker #(
  parameter int unsigned W    = 32,
  parameter int unsigned STEP = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pc_drive,
  input logic         mdr_drive,
  input logic         ir_drive_ofs,
  input logic         z_drive,
  input logic         gpr_drive,
  input logic         mar_load,
  input logic         mdr_load_int,
  input logic         mdr_load_ext,
  input logic         z_load,
  input logic         opa_sel_four,
  input logic         mem_mfc,
  input logic [W-1:0] mem_rdata,
  input logic [W-1:0] alu_a,
  input logic [W-1:0] alu_b,
  input logic [W-1:0] alu_y,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic [W-1:0] bus_q
);

  assert_single_driver_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_drive, mdr_drive, ir_drive_ofs, z_drive, gpr_drive}));

  assert_idle_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_drive || mdr_drive || ir_drive_ofs || z_drive || gpr_drive) |-> bus_q == '0);

  assert_mar_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mar_load |=> mem_addr == $past(bus_q));

  assert_mar_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mar_load |=> $stable(mem_addr));

  assert_mdr_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdr_load_ext && mem_mfc) |=> mem_wdata == $past(mem_rdata));

  assert_mdr_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mdr_load_int && !(mdr_load_ext && mem_mfc)) |=> mem_wdata == $past(bus_q));

  assert_ofs_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ir_drive_ofs |-> bus_q[W-1:16] == {(W-16){bus_q[15]}});

  assert_opa_four_R9: assert property (@(posedge clk) disable iff (!rst_n)
    opa_sel_four |-> (alu_a == W'(STEP)) && (alu_b == bus_q));

  assert_z_roundtrip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(z_load) && z_drive) |-> bus_q == $past(alu_y));

endmodule

bind sbus_datapath sbus_checker #(.W(W), .STEP(STEP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pc_drive    (pc_drive),
  .mdr_drive   (mdr_drive),
  .ir_drive_ofs(ir_drive_ofs),
  .z_drive     (z_drive),
  .gpr_drive   (gpr_drive),
  .mar_load    (mar_load),
  .mdr_load_int(mdr_load_int),
  .mdr_load_ext(mdr_load_ext),
  .z_load      (z_load),
  .opa_sel_four(opa_sel_four),
  .mem_mfc     (mem_mfc),
  .mem_rdata   (mem_rdata),
  .alu_a       (alu_a),
  .alu_b       (alu_b),
  .alu_y       (alu_y),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .bus_q       (bus_q)
);

// File: tb/sim_sbus_datapath.sv
`timescale 1ns/1ps
module sim_sbus_datapath;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pc_drive, pc_load, mar_load, mdr_drive, mdr_load_int, mdr_load_ext;
  logic        ir_drive_ofs, ir_load, y_load, z_drive, z_load, gpr_drive, gpr_load;
  logic [4:0]  gpr_rd_sel, gpr_wr_sel;
  logic        opa_sel_four, rd_req, wr_req, mem_mfc;
  logic [31:0] alu_y, mem_rdata;
  logic [31:0] alu_a, alu_b, mem_addr, mem_wdata, bus_q;
  logic        mem_rd, mem_wr;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sbus_datapath u0 (.*);

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic idle;
    pc_drive = 0; pc_load = 0; mar_load = 0; mdr_drive = 0; mdr_load_int = 0;
    mdr_load_ext = 0; ir_drive_ofs = 0; ir_load = 0; y_load = 0; z_drive = 0;
    z_load = 0; gpr_drive = 0; gpr_load = 0; gpr_rd_sel = 0; gpr_wr_sel = 0;
    opa_sel_four = 0; rd_req = 0; wr_req = 0; mem_mfc = 0;
    alu_y = 0; mem_rdata = 0;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Capture v into Z, then leave Z driving the bus.
  task automatic stage_z(input logic [31:0] v);
    idle; alu_y = v; z_load = 1; tick;
    idle; z_drive = 1; #1;
  endtask

  function automatic logic [31:0] gval(input int i);
    return 32'h9E3779B9 * (i + 1) ^ 32'h00C0FFEE;
  endfunction

  function automatic logic [31:0] sext(input logic [31:0] w);
    return {{16{w[15]}}, w[15:0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] ofs_pat [5];
    idle;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) tick;

    // R1: reset state
    chk(mem_addr == 0, "R1 mem_addr", mem_addr, 0);
    chk(mem_wdata == 0, "R1 mem_wdata", mem_wdata, 0);
    chk(alu_a == 0, "R1 alu_a", alu_a, 0);
    chk(bus_q == 0, "R2 idle bus", bus_q, 0);
    pc_drive = 1; #1;
    chk(bus_q == 0, "R1 pc", bus_q, 0);
    idle; gpr_drive = 1; gpr_rd_sel = 5'd17; #1;
    chk(bus_q == 0, "R1 gpr", bus_q, 0);

    // R3: sweep all general registers
    for (int i = 0; i < 32; i++) begin
      stage_z(gval(i)); gpr_load = 1; gpr_wr_sel = 5'(i); tick;
    end
    for (int i = 0; i < 32; i++) begin
      idle; gpr_drive = 1; gpr_rd_sel = 5'(i); #1;
      chk(bus_q == gval(i), "R3 gpr sweep", bus_q, gval(i));
    end
    // R3: register-to-register copy in one step
    idle; gpr_drive = 1; gpr_rd_sel = 5'd3; gpr_load = 1; gpr_wr_sel = 5'd7; tick;
    idle; gpr_drive = 1; gpr_rd_sel = 5'd7; #1;
    chk(bus_q == gval(3), "R3 copy dst", bus_q, gval(3));
    gpr_rd_sel = 5'd3; #1;
    chk(bus_q == gval(3), "R3 copy src", bus_q, gval(3));
    gpr_rd_sel = 5'd8; #1;
    chk(bus_q == gval(8), "R3 neighbour", bus_q, gval(8));

    // R4, R9, R10: PC load and increment through constant 4 and Z
    stage_z(32'h0000_1000); pc_load = 1; tick;
    idle; pc_drive = 1; #1;
    chk(bus_q == 32'h1000, "R4 pc load", bus_q, 32'h1000);
    opa_sel_four = 1; #1;
    chk(alu_a == 4, "R9 const four", alu_a, 4);
    chk(alu_b == 32'h1000, "R9 alu_b bus", alu_b, 32'h1000);
    alu_y = alu_a + alu_b; z_load = 1; tick;
    idle; z_drive = 1; pc_load = 1; #1;
    chk(bus_q == 32'h1004, "R10 z drive", bus_q, 32'h1004);
    tick;
    idle; pc_drive = 1; #1;
    chk(bus_q == 32'h1004, "R4 pc incremented", bus_q, 32'h1004);

    // R9: Y path
    stage_z(32'hDEAD_0042); y_load = 1; tick;
    idle; #1;
    chk(alu_a == 32'hDEAD_0042, "R9 y operand", alu_a, 32'hDEAD_0042);

    // R5: address register
    stage_z(32'h0000_2468); mar_load = 1; tick;
    idle; #1;
    chk(mem_addr == 32'h2468, "R5 mar load", mem_addr, 32'h2468);
    stage_z(32'h1111_1111); tick;
    idle; #1;
    chk(mem_addr == 32'h2468, "R5 mar hold", mem_addr, 32'h2468);

    // R6: memory capture waits for completion
    idle; mdr_load_ext = 1; mem_rdata = 32'hCAFE_BABE; mem_mfc = 0; tick;
    chk(mem_wdata == 0, "R6 hold no mfc", mem_wdata, 0);
    mem_mfc = 1; tick;
    idle; #1;
    chk(mem_wdata == 32'hCAFE_BABE, "R6 capture", mem_wdata, 32'hCAFE_BABE);

    // R8: offset extension sweep via memory -> MDR -> IR
    ofs_pat[0] = 32'hABCD_0000; ofs_pat[1] = 32'h5A5A_7FFF; ofs_pat[2] = 32'h0000_8000;
    ofs_pat[3] = 32'h1234_FFFF; ofs_pat[4] = 32'hFFFF_1234;
    for (int k = 0; k < 5; k++) begin
      idle; mdr_load_ext = 1; mem_mfc = 1; mem_rdata = ofs_pat[k]; tick;
      idle; mdr_drive = 1; #1;
      chk(bus_q == ofs_pat[k], "R6 mdr drive", bus_q, ofs_pat[k]);
      ir_load = 1; tick;
      idle; ir_drive_ofs = 1; #1;
      chk(bus_q == sext(ofs_pat[k]), "R8 offset sext", bus_q, sext(ofs_pat[k]));
    end

    // R7: bus load into MDR, and memory priority
    stage_z(32'h0F0F_F0F0); mdr_load_int = 1; tick;
    idle; #1;
    chk(mem_wdata == 32'h0F0F_F0F0, "R7 bus load", mem_wdata, 32'h0F0F_F0F0);
    stage_z(32'h7777_7777); mdr_load_int = 1; mdr_load_ext = 1; mem_mfc = 1;
    mem_rdata = 32'h3333_4444; tick;
    idle; #1;
    chk(mem_wdata == 32'h3333_4444, "R7 memory wins", mem_wdata, 32'h3333_4444);

    // R11: request strobes
    idle; rd_req = 1; #1;
    chk({mem_rd, mem_wr} == 2'b10, "R11 read", {30'b0, mem_rd, mem_wr}, 2);
    rd_req = 0; wr_req = 1; #1;
    chk({mem_rd, mem_wr} == 2'b01, "R11 write", {30'b0, mem_rd, mem_wr}, 1);
    idle; #1;
    chk({mem_rd, mem_wr} == 2'b00, "R11 none", {30'b0, mem_rd, mem_wr}, 0);

    tick;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule